// File: doc/BRIEF.md
# Flash status and write-protect controller

This block keeps the eight-bit status byte of a serial flash device and decides, one command at a time, whether an already decoded write-class request may start. Request strobes come from the command decoder one clock wide: set write-enable, clear write-enable, status write (with its data byte and the number of bus cycles the command used), small-sector erase, sector erase, chip erase, page program and power-down. They come with the target address, the level of the write-protect pin, and a done pulse from the internal operation timer.

For each accepted request the block raises a one-cycle grant, registers the aligned target address for the array sequencer and marks the device busy until the timer reports done. The write-enable latch, the two block-protect bits and the status lock bit are held in registers that reset to zero.

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset `status_o` is 00h, `busy_o` is 0 and no grant is high.
- R2: A set-enable strobe makes status bit 1 (WEN) 1 and a clear-enable strobe makes it 0. When both arrive in the same cycle, WEN ends 0.
- R3: A granted erase, program or status write sets `busy_o` and status bit 0 on the same edge as its grant. `op_done_i` while busy clears both and also clears WEN. While busy, every write-class and power-down request is refused and leaves the status unchanged.
- R4: Erase, program and status write are granted only when WEN is 1. A refused request leaves WEN as it was.
- R5: Protect level {bit3,bit2} = 00 protects nothing, 01 protects 18000h–1FFFFh, 10 protects 10000h–1FFFFh and 11 protects the whole space. Erase or program aimed at a protected address is refused.
- R6: Chip erase is granted only when status bits 3 and 2 are both 0.
- R7: A granted status write loads status bits 2, 3 and 7 from the same data bits. Other data bits are ignored, and status bits 6 to 4 always read 0.
- R8: A status write is refused when status bit 7 is 1 and `wp_n_i` is low. With `wp_n_i` high it is accepted whatever bit 7 holds.
- R9: A status write is granted only when `wrsr_cycles_i` equals 2.
- R10: `op_addr_o` takes the aligned target on an erase or program grant: the address with bits 11..0 cleared for a small-sector erase, with bits 14..0 cleared for a sector erase, zero for chip erase, and the full address for page program.
- R11: A set-enable strobe in the same cycle as `op_done_i` leaves WEN at 1 while busy clears.
- R12: At most one grant is high per cycle. When several requests arrive together, the priority is status write, chip erase, sector erase, small-sector erase, page program, then power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_i | input | 1 | Set write-enable request |
| wrdis_i | input | 1 | Clear write-enable request |
| wrsr_i | input | 1 | Status write request |
| wrsr_data_i | input | 8 | Status write data byte |
| wrsr_cycles_i | input | CYC_W | Bus cycles seen in the status write command |
| sse_i | input | 1 | Small-sector erase request |
| se_i | input | 1 | Sector erase request |
| ce_i | input | 1 | Chip erase request |
| pp_i | input | 1 | Page program request |
| pd_i | input | 1 | Power-down request |
| addr_i | input | ADDR_W | Target address |
| wp_n_i | input | 1 | Write-protect pin level (low asserts) |
| op_done_i | input | 1 | Operation timer done pulse |
| status_o | output | 8 | Status byte |
| gnt_sse_o | output | 1 | Small-sector erase grant |
| gnt_se_o | output | 1 | Sector erase grant |
| gnt_ce_o | output | 1 | Chip erase grant |
| gnt_pp_o | output | 1 | Page program grant |
| gnt_wrsr_o | output | 1 | Status write grant |
| gnt_pd_o | output | 1 | Power-down grant |
| busy_o | output | 1 | Operation in progress |
| op_addr_o | output | ADDR_W | Aligned target of the last erase or program grant |

## Verification
The timer's done pulse and a new write-enable request can land on the same edge. One source clears WEN and the other sets it. The bench starts a small-sector erase, then drives `op_done_i` and `wren_i` together in one cycle. It expects status 02h afterwards: busy gone and WEN still set. A second overlap pairs set-enable and clear-enable strobes in one cycle and expects WEN to be 0. A third drives two erase and program requests at once and expects only the higher-priority grant.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_SSE  = 3'd1,
    OP_SE   = 3'd2,
    OP_CE   = 3'd3,
    OP_PP   = 3'd4,
    OP_WRSR = 3'd5,
    OP_PD   = 3'd6
  } op_e;

  localparam int ST_W     = 8;
  localparam int ST_BUSY  = 0;
  localparam int ST_WEN   = 1;
  localparam int ST_LVL_L = 2;
  localparam int ST_LVL_H = 3;
  localparam int ST_LOCK  = 7;
  localparam int NUM_GNT  = 6;
endpackage

// File: rtl/fwp_prot_chk.sv
module fwp_prot_chk #(
  parameter int ADDR_W = 17
) (
  input  logic [1:0]        lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [1:0] top2;
  assign top2 = addr_i[ADDR_W-1 -: 2];

  always_comb begin
    case (lvl_i)
      2'b00:   hit_o = 1'b0;
      2'b01:   hit_o = (top2 == 2'b11);
      2'b10:   hit_o = top2[1];
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/fwp_cmd_arb.sv
module fwp_cmd_arb
  import fwp_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int CYC_W   = 4,
  parameter int SUB_LSB = 12,
  parameter int SEC_LSB = 15
) (
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic [CYC_W-1:0]  wrsr_cycles_i,
  input  logic              sse_i,
  input  logic              se_i,
  input  logic              ce_i,
  input  logic              pp_i,
  input  logic              pd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic              wen_i,
  input  logic [1:0]        lvl_i,
  input  logic              lock_i,
  output op_e               sel_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic [7:0]        load_o
);
  localparam logic [ADDR_W-1:0] SUB_MASK = {ADDR_W{1'b1}} << SUB_LSB;
  localparam logic [ADDR_W-1:0] SEC_MASK = {ADDR_W{1'b1}} << SEC_LSB;
  localparam logic [CYC_W-1:0]  WRSR_LEN = CYC_W'(2);

  logic hit;
  logic may_write;
  logic lock_act;

  fwp_prot_chk #(.ADDR_W(ADDR_W)) u_prot (
    .lvl_i (lvl_i),
    .addr_i(addr_i),
    .hit_o (hit)
  );

  assign may_write = !busy_i && wen_i;
  assign lock_act  = lock_i && !wp_n_i;
  assign load_o    = wrsr_data_i;

  always_comb begin
    sel_o = OP_NONE;
    tgt_o = '0;
    if (wrsr_i && may_write && !lock_act && (wrsr_cycles_i == WRSR_LEN)) begin
      sel_o = OP_WRSR;
    end else if (ce_i && may_write && (lvl_i == 2'b00)) begin
      sel_o = OP_CE;
    end else if (se_i && may_write && !hit) begin
      sel_o = OP_SE;
      tgt_o = addr_i & SEC_MASK;
    end else if (sse_i && may_write && !hit) begin
      sel_o = OP_SSE;
      tgt_o = addr_i & SUB_MASK;
    end else if (pp_i && may_write && !hit) begin
      sel_o = OP_PP;
      tgt_o = addr_i;
    end else if (pd_i && !busy_i) begin
      sel_o = OP_PD;
    end
  end
endmodule

// File: rtl/fwp_status_reg.sv
module fwp_status_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_wen_i,
  input  logic       clr_wen_i,
  input  logic       start_i,
  input  logic       done_i,
  input  logic       load_i,
  input  logic [7:0] load_data_i,
  output logic       busy_o,
  output logic       wen_o,
  output logic [1:0] lvl_o,
  output logic       lock_o
);
  logic       busy_q, busy_d;
  logic       wen_q, wen_d;
  logic [1:0] lvl_q, lvl_d;
  logic       lock_q, lock_d;
  logic       finish;
  logic       en;

  assign finish = busy_q && done_i;
  assign en     = set_wen_i || clr_wen_i || start_i || finish || load_i;

  always_comb begin
    busy_d = busy_q;
    wen_d  = wen_q;
    lvl_d  = lvl_q;
    lock_d = lock_q;
    if (finish) begin
      busy_d = 1'b0;
      wen_d  = 1'b0;
    end
    if (start_i)   busy_d = 1'b1;
    if (set_wen_i) wen_d  = 1'b1;
    if (clr_wen_i) wen_d  = 1'b0;
    if (load_i) begin
      lvl_d  = load_data_i[3:2];
      lock_d = load_data_i[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wen_q  <= 1'b0;
      lvl_q  <= 2'b00;
      lock_q <= 1'b0;
    end else if (en) begin
      busy_q <= busy_d;
      wen_q  <= wen_d;
      lvl_q  <= lvl_d;
      lock_q <= lock_d;
    end
  end

  assign busy_o = busy_q;
  assign wen_o  = wen_q;
  assign lvl_o  = lvl_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import fwp_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int CYC_W   = 4,
  parameter int SUB_LSB = 12,
  parameter int SEC_LSB = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              wrdis_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic [CYC_W-1:0]  wrsr_cycles_i,
  input  logic              sse_i,
  input  logic              se_i,
  input  logic              ce_i,
  input  logic              pp_i,
  input  logic              pd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_n_i,
  input  logic              op_done_i,
  output logic [7:0]        status_o,
  output logic              gnt_sse_o,
  output logic              gnt_se_o,
  output logic              gnt_ce_o,
  output logic              gnt_pp_o,
  output logic              gnt_wrsr_o,
  output logic              gnt_pd_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] op_addr_o
);
  op_e               sel;
  logic [ADDR_W-1:0] tgt;
  logic [7:0]        load_data;
  logic              busy, wen, lock;
  logic [1:0]        lvl;
  logic              start, array_op;
  logic [NUM_GNT-1:0] gnt_d, gnt_q;
  logic [ADDR_W-1:0] op_addr_q;

  fwp_cmd_arb #(
    .ADDR_W (ADDR_W),
    .CYC_W  (CYC_W),
    .SUB_LSB(SUB_LSB),
    .SEC_LSB(SEC_LSB)
  ) u_arb (
    .wrsr_i       (wrsr_i),
    .wrsr_data_i  (wrsr_data_i),
    .wrsr_cycles_i(wrsr_cycles_i),
    .sse_i        (sse_i),
    .se_i         (se_i),
    .ce_i         (ce_i),
    .pp_i         (pp_i),
    .pd_i         (pd_i),
    .addr_i       (addr_i),
    .wp_n_i       (wp_n_i),
    .busy_i       (busy),
    .wen_i        (wen),
    .lvl_i        (lvl),
    .lock_i       (lock),
    .sel_o        (sel),
    .tgt_o        (tgt),
    .load_o       (load_data)
  );

  assign array_op = (sel == OP_SSE) || (sel == OP_SE) || (sel == OP_CE) || (sel == OP_PP);
  assign start    = array_op || (sel == OP_WRSR);

  fwp_status_reg u_st (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_wen_i  (wren_i),
    .clr_wen_i  (wrdis_i),
    .start_i    (start),
    .done_i     (op_done_i),
    .load_i     (sel == OP_WRSR),
    .load_data_i(load_data),
    .busy_o     (busy),
    .wen_o      (wen),
    .lvl_o      (lvl),
    .lock_o     (lock)
  );

  // grant vector order: sse, se, ce, pp, wrsr, pd (bit 0 upward)
  always_comb begin
    gnt_d = '0;
    case (sel)
      OP_SSE:  gnt_d[0] = 1'b1;
      OP_SE:   gnt_d[1] = 1'b1;
      OP_CE:   gnt_d[2] = 1'b1;
      OP_PP:   gnt_d[3] = 1'b1;
      OP_WRSR: gnt_d[4] = 1'b1;
      OP_PD:   gnt_d[5] = 1'b1;
      default: gnt_d    = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
    end else begin
      gnt_q <= gnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr_q <= '0;
    end else if (array_op) begin
      op_addr_q <= tgt;
    end
  end

  assign gnt_sse_o  = gnt_q[0];
  assign gnt_se_o   = gnt_q[1];
  assign gnt_ce_o   = gnt_q[2];
  assign gnt_pp_o   = gnt_q[3];
  assign gnt_wrsr_o = gnt_q[4];
  assign gnt_pd_o   = gnt_q[5];
  assign busy_o     = busy;
  assign op_addr_o  = op_addr_q;

  always_comb begin
    status_o          = '0;
    status_o[ST_BUSY] = busy;
    status_o[ST_WEN]  = wen;
    status_o[ST_LVL_L] = lvl[0];
    status_o[ST_LVL_H] = lvl[1];
    status_o[ST_LOCK] = lock;
  end
endmodule

// File: rtl/fwp_chk.sv
module fwp_chk #(
  parameter int CYC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wren_i,
  input logic [CYC_W-1:0] wrsr_cycles_i,
  input logic             wp_n_i,
  input logic             op_done_i,
  input logic [7:0]       status_o,
  input logic             gnt_sse_o,
  input logic             gnt_se_o,
  input logic             gnt_ce_o,
  input logic             gnt_pp_o,
  input logic             gnt_wrsr_o,
  input logic             gnt_pd_o,
  input logic             busy_o
);
  logic wr_gnt;
  assign wr_gnt = gnt_sse_o || gnt_se_o || gnt_ce_o || gnt_pp_o || gnt_wrsr_o;

  // R3
  busy_with_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gnt |-> (busy_o && status_o[0]));

  // R3
  no_grant_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_gnt || gnt_pd_o) |-> !$past(busy_o));

  // R3
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && op_done_i && !wren_i) |=> (!busy_o && !status_o[1]));

  // R4
  wen_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gnt |-> $past(status_o[1]));

  // R6
  ce_unprotected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_ce_o |-> ($past(status_o[3:2]) == 2'b00));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:4] == 3'b000);

  // R8
  lock_honoured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_wrsr_o |-> ($past(wp_n_i) || !$past(status_o[7])));

  // R9
  wrsr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_wrsr_o |-> ($past(wrsr_cycles_i) == CYC_W'(2)));

  // R11
  done_and_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && op_done_i && wren_i) |=> (!busy_o && status_o[1]));

  // R12
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_sse_o, gnt_se_o, gnt_ce_o, gnt_pp_o, gnt_wrsr_o, gnt_pd_o}));
endmodule

bind flash_wp_ctrl fwp_chk #(.CYC_W(CYC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wren_i       (wren_i),
  .wrsr_cycles_i(wrsr_cycles_i),
  .wp_n_i       (wp_n_i),
  .op_done_i    (op_done_i),
  .status_o     (status_o),
  .gnt_sse_o    (gnt_sse_o),
  .gnt_se_o     (gnt_se_o),
  .gnt_ce_o     (gnt_ce_o),
  .gnt_pp_o     (gnt_pp_o),
  .gnt_wrsr_o   (gnt_wrsr_o),
  .gnt_pd_o     (gnt_pd_o),
  .busy_o       (busy_o)
);

// File: tb/sim_flash_wp_ctrl.sv
module sim_flash_wp_ctrl;
  localparam int AW = 17;
  localparam int CW = 4;

  // request mask bits
  localparam logic [7:0] M_WREN = 8'h01, M_WRDIS = 8'h02, M_WRSR = 8'h04, M_SSE = 8'h08;
  localparam logic [7:0] M_SE = 8'h10, M_CE = 8'h20, M_PP = 8'h40, M_PD = 8'h80;

  typedef struct packed {
    logic [3:0]    req;
    logic [7:0]    mask;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    logic          wp;
    logic [5:0]    gnt;   // {pd,wrsr,pp,ce,se,sse}
    logic [7:0]    st;
    logic [AW-1:0] ea;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{4'd4,  M_PP,   17'h00000, 8'h00, 1'b1, 6'h00, 8'h00, 17'h00000}, // R4 no WEN
    '{4'd2,  M_WREN, 17'h00000, 8'h00, 1'b1, 6'h00, 8'h02, 17'h00000}, // R2
    '{4'd3,  M_PP,   17'h00100, 8'h00, 1'b1, 6'h08, 8'h03, 17'h00100}, // R3 R10
    '{4'd2,  M_WREN, 17'h00000, 8'h00, 1'b1, 6'h00, 8'h02, 17'h00000}, // R2
    '{4'd7,  M_WRSR, 17'h00000, 8'h04, 1'b1, 6'h10, 8'h07, 17'h00000}, // R7 level 01
    '{4'd2,  M_WREN, 17'h00000, 8'h00, 1'b1, 6'h00, 8'h06, 17'h00000}, // R2
    '{4'd5,  M_SSE,  17'h18000, 8'h00, 1'b1, 6'h00, 8'h06, 17'h00000}, // R5 protected, WEN kept
    '{4'd10, M_SE,   17'h17FFF, 8'h00, 1'b1, 6'h02, 8'h07, 17'h10000}, // R10 R5
    '{4'd2,  M_WREN, 17'h00000, 8'h00, 1'b1, 6'h00, 8'h06, 17'h00000}, // R2
    '{4'd6,  M_CE,   17'h00000, 8'h00, 1'b1, 6'h00, 8'h06, 17'h00000}, // R6 refused
    '{4'd7,  M_WRSR, 17'h00000, 8'hFB, 1'b1, 6'h10, 8'h8B, 17'h00000}, // R7 only 7,3,2 taken
    '{4'd2,  M_WREN, 17'h00000, 8'h00, 1'b1, 6'h00, 8'h8A, 17'h00000}, // R2
    '{4'd5,  M_SSE,  17'h0F000, 8'h00, 1'b1, 6'h01, 8'h8B, 17'h0F000}, // R5 level 10 below
    '{4'd2,  M_WREN, 17'h00000, 8'h00, 1'b1, 6'h00, 8'h8A, 17'h00000}, // R2
    '{4'd5,  M_PP,   17'h10000, 8'h00, 1'b1, 6'h00, 8'h8A, 17'h00000}, // R5 level 10 inside
    '{4'd8,  M_WRSR, 17'h00000, 8'h00, 1'b0, 6'h00, 8'h8A, 17'h00000}, // R8 locked
    '{4'd3,  M_PD,   17'h00000, 8'h00, 1'b1, 6'h20, 8'h8A, 17'h00000}, // R3 power-down idle
    '{4'd8,  M_WRSR, 17'h00000, 8'h00, 1'b1, 6'h10, 8'h03, 17'h00000}, // R8 pin high
    '{4'd2,  M_WREN, 17'h00000, 8'h00, 1'b1, 6'h00, 8'h02, 17'h00000}, // R2
    '{4'd6,  M_CE,   17'h00000, 8'h00, 1'b1, 6'h04, 8'h03, 17'h00000}, // R6 granted
    '{4'd2,  M_WREN, 17'h00000, 8'h00, 1'b1, 6'h00, 8'h02, 17'h00000}, // R2
    '{4'd2,  M_WRDIS,17'h00000, 8'h00, 1'b1, 6'h00, 8'h00, 17'h00000}  // R2
  };

  logic clk, rst_n;
  logic wren, wrdis, wrsr, sse, se, ce, pp, pd, wp_n, op_done;
  logic [7:0] wdata;
  logic [CW-1:0] wcyc;
  logic [AW-1:0] addr;
  logic [7:0] status;
  logic g_sse, g_se, g_ce, g_pp, g_wrsr, g_pd, busy;
  logic [AW-1:0] op_addr;
  logic [5:0] gvec;
  int n_chk, n_bad;

  assign gvec = {g_pd, g_wrsr, g_pp, g_ce, g_se, g_sse};

  flash_wp_ctrl #(.ADDR_W(AW), .CYC_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .wren_i(wren), .wrdis_i(wrdis), .wrsr_i(wrsr),
    .wrsr_data_i(wdata), .wrsr_cycles_i(wcyc), .sse_i(sse), .se_i(se), .ce_i(ce),
    .pp_i(pp), .pd_i(pd), .addr_i(addr), .wp_n_i(wp_n), .op_done_i(op_done),
    .status_o(status), .gnt_sse_o(g_sse), .gnt_se_o(g_se), .gnt_ce_o(g_ce),
    .gnt_pp_o(g_pp), .gnt_wrsr_o(g_wrsr), .gnt_pd_o(g_pd), .busy_o(busy),
    .op_addr_o(op_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_reqs();
    {wren, wrdis, wrsr, sse, se, ce, pp, pd} = '0;
  endtask

  task automatic drive(input logic [7:0] m, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic [CW-1:0] nc, input logic w);
    @(negedge clk);
    {pd, pp, ce, se, sse, wrsr, wrdis, wren} = m;
    addr = a; wdata = d; wcyc = nc; wp_n = w;
    @(negedge clk);
    clear_reqs();
  endtask

  task automatic finish_op();
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    clear_reqs();
    op_done = 1'b0; wdata = '0; wcyc = CW'(2); addr = '0; wp_n = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status", 32'(status), 32'h00);
    check("R1 busy", 32'(busy), 32'h0);
    check("R1 grants", 32'(gvec), 32'h00);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].mask, VEC[i].addr, VEC[i].data, CW'(2), VEC[i].wp);
      check($sformatf("R%0d vec%0d grant", VEC[i].req, i), 32'(gvec), 32'(VEC[i].gnt));
      check($sformatf("R%0d vec%0d status", VEC[i].req, i), 32'(status), 32'(VEC[i].st));
      if (VEC[i].gnt[3:0] != 4'h0)
        check($sformatf("R10 vec%0d target", i), 32'(op_addr), 32'(VEC[i].ea));
      if (busy) begin
        finish_op();
        check($sformatf("R3 vec%0d done clears busy/WEN", i), 32'(status[1:0]), 32'h0);
      end
    end

    // R9: wrong bus-cycle counts
    drive(M_WREN, '0, 8'h00, CW'(2), 1'b1);
    drive(M_WRSR, '0, 8'h04, CW'(3), 1'b1);
    check("R9 three cycles refused", {26'd0, gvec}, 32'h00);
    check("R9 status kept", 32'(status), 32'h02);
    drive(M_WRSR, '0, 8'h04, CW'(1), 1'b1);
    check("R9 one cycle refused", 32'(status), 32'h02);

    // R5 level 11
    drive(M_WRSR, '0, 8'h0C, CW'(2), 1'b1);
    check("R5 set level 11", 32'(status), 32'h0F);
    finish_op();
    drive(M_WREN, '0, 8'h00, CW'(2), 1'b1);
    drive(M_PP, 17'h00000, 8'h00, CW'(2), 1'b1);
    check("R5 level 11 refuses low address", 32'(gvec), 32'h00);
    check("R4 WEN kept after refusal", 32'(status), 32'h0E);
    drive(M_WRSR, '0, 8'h00, CW'(2), 1'b1);
    finish_op();
    check("R5 level restored", 32'(status), 32'h00);

    // R3 busy refusal, R10 small-sector alignment
    drive(M_WREN, '0, 8'h00, CW'(2), 1'b1);
    drive(M_SSE, 17'h0ABCD, 8'h00, CW'(2), 1'b1);
    check("R10 small sector target", 32'(op_addr), 32'h0A000);
    check("R3 busy set", 32'(status), 32'h03);
    drive(M_PP, 17'h00000, 8'h00, CW'(2), 1'b1);
    check("R3 program refused while busy", 32'(gvec), 32'h00);
    drive(M_PD, 17'h00000, 8'h00, CW'(2), 1'b1);
    check("R3 power-down refused while busy", 32'(gvec), 32'h00);
    check("R3 status unchanged while busy", 32'(status), 32'h03);

    // R11: done and set-enable in one cycle
    @(negedge clk);
    op_done = 1'b1; wren = 1'b1;
    @(negedge clk);
    op_done = 1'b0; wren = 1'b0;
    check("R11 WEN kept, busy cleared", 32'(status), 32'h02);

    // R12: two requests together
    drive(M_SSE | M_PP, 17'h01234, 8'h00, CW'(2), 1'b1);
    check("R12 small sector beats program", 32'(gvec), 32'h01);
    check("R12 target of winner", 32'(op_addr), 32'h01000);
    finish_op();
    check("R3 done clears", 32'(status), 32'h00);

    // R2: set and clear together
    drive(M_WREN | M_WRDIS, '0, 8'h00, CW'(2), 1'b1);
    check("R2 clear wins", 32'(status), 32'h00);

    // R1: reset mid-run
    drive(M_WREN, '0, 8'h00, CW'(2), 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset clears status", 32'(status), 32'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule